// File: doc/BRIEF.md
# Double-Buffered Real-Time Clock Update Controller

This block keeps a calendar time (seconds up to year) in a set of live counters that step forward once per second. A prescaler driven by a slow tick input produces the once-per-second strobe. The host never reaches those counters directly. It sees a user copy instead, which follows the live counters while the host is not holding it. When the host sets a hold bit, the copy freezes on a snapshot. The host can then read a consistent time, or write a new one into the copy, while the live chain keeps counting.

Clearing the hold bit schedules a write-back of the copy into the live counters. The write-back is placed so that it never lands on the same cycle as a once-per-second step. If the host releases the hold during the warning window just before a step, the write-back waits until the cycle after that step.

The block also gives the host three ways to learn when an update happens:
- a status bit that warns of an update a fixed number of ticks ahead,
- an update-done flag,
- a periodic flag at a selectable rate.

The two flags have enable bits, and together they drive a single interrupt request. The flag register clears when it is read.

Top module: `rtc_shadow_ctrl`

## Requirements
- R1: The live seconds count advances by exactly one for every TICKS_PER_SEC tick pulses. The prescaler holds while tick is low.
- R2: Carry chain (binary values):
  - seconds and minutes wrap 59→0, and hours wrap 23→0;
  - day of month wraps to 1 after the month's last day: 30 for months 4, 6, 9 and 11, 31 for the other months, and for February 29 when year mod 4 is 0 and 28 otherwise;
  - month wraps 12→1;
  - year wraps 99→0.
- R3: Register map (3-bit address): 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6 control, 7 flags. While hold is 0 and no write-back is pending, addresses 0–5 read the live time as it was one cycle earlier, and bus writes to them are ignored.
- R4: Control register bit 0 is hold. Writing it to 1 captures the live time into the copy at that clock edge. While hold is 1, reads of addresses 0–5 return the captured or written values, and writes change only the copy. The prescaler and the update flag keep running.
- R5: Writing hold from 1 to 0 outside the warning window loads the copy into the live counters on the next clock edge. A write-back never shares a cycle with a once-per-second step.
- R6: Writing hold from 1 to 0 while the warning bit is 1 defers the write-back to the edge after the step. The values written by the host are kept, and the step just taken is discarded.
- R7: Flags bit 0 (warning) reads 1 exactly while the prescaler is within the last WARN_TICKS ticks before a step, and reads 0 otherwise.
- R8: Flags bit 1 is set by every step. Flags bit 2 is set once every 2^(r+1) ticks, where r is control bits 6:4 (r=0 disables it).
- R9: A bus read of address 7 clears flag bits 1 and 2 on that edge. If an event sets a flag on the same edge, the event wins.
- R10: irq, and flags bit 7, equal (bit1 AND control bit 1) OR (bit2 AND control bit 2). irq stays high until the host clears the flag by reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse from the slow time base |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for clear-on-read) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench releases the hold bit four ticks before a step. A design that wrote back at once would let that step run on the restored time, so the seconds would read 0 instead of the 59 the host wrote. Other runs cross the end of a leap February, a non-leap February and the end of year 99; a wrong month-length or year-mod-4 rule shows up as a wrong day or month. The bench also reads the flags on the very edge of a step: a design where the clear beats the set would lose that update-done event. A write made without hold must leave the readback unchanged, which catches a design that lets the host reach the live counters.

// File: rtl/rtc_pkg.sv
// Shared types and helpers for the double-buffered clock.
// Assumes binary (not BCD) field encoding and a two-digit year.
package rtc_pkg;

    typedef struct packed {
        logic [6:0] yr;
        logic [3:0] mon;
        logic [4:0] day;
        logic [4:0] hr;
        logic [5:0] mn;
        logic [5:0] sc;
    } rtc_time_t;

    localparam logic [2:0] ADR_SEC  = 3'd0;
    localparam logic [2:0] ADR_MIN  = 3'd1;
    localparam logic [2:0] ADR_HOUR = 3'd2;
    localparam logic [2:0] ADR_DAY  = 3'd3;
    localparam logic [2:0] ADR_MON  = 3'd4;
    localparam logic [2:0] ADR_YEAR = 3'd5;
    localparam logic [2:0] ADR_CTRL = 3'd6;
    localparam logic [2:0] ADR_FLAG = 3'd7;

    localparam rtc_time_t RTC_RESET_TIME = '{yr: 7'd0, mon: 4'd1, day: 5'd1,
                                             hr: 5'd0, mn: 6'd0, sc: 6'd0};

    // Number of days in a month; year mod 4 == 0 gives a leap February.
    function automatic logic [4:0] rtc_month_len(logic [3:0] mon, logic [6:0] yr);
        if (mon == 4'd2)
            return (yr[1:0] == 2'd0) ? 5'd29 : 5'd28;
        else if (mon == 4'd4 || mon == 4'd6 || mon == 4'd9 || mon == 4'd11)
            return 5'd30;
        else
            return 5'd31;
    endfunction

    // One-second step through the whole carry chain.
    function automatic rtc_time_t rtc_advance(rtc_time_t t);
        rtc_time_t n;
        n = t;
        if (t.sc < 6'd59) begin
            n.sc = t.sc + 6'd1;
        end else begin
            n.sc = 6'd0;
            if (t.mn < 6'd59) begin
                n.mn = t.mn + 6'd1;
            end else begin
                n.mn = 6'd0;
                if (t.hr < 5'd23) begin
                    n.hr = t.hr + 5'd1;
                end else begin
                    n.hr = 5'd0;
                    if (t.day < rtc_month_len(t.mon, t.yr)) begin
                        n.day = t.day + 5'd1;
                    end else begin
                        n.day = 5'd1;
                        if (t.mon < 4'd12) begin
                            n.mon = t.mon + 4'd1;
                        end else begin
                            n.mon = 4'd1;
                            n.yr  = (t.yr < 7'd99) ? t.yr + 7'd1 : 7'd0;
                        end
                    end
                end
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Divides the tick input down to a once-per-second step strobe.
// Also flags the warning window and the periodic event.
// Assumes TICKS_PER_SEC is a power of two and WARN_TICKS < TICKS_PER_SEC.
module rtc_prescaler #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int WARN_TICKS    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] rate,
    output logic       step,
    output logic       warn,
    output logic       per_evt
);
    localparam int CNT_W = $clog2(TICKS_PER_SEC);
    localparam int EXT_W = (CNT_W > 8) ? CNT_W : 8;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TICKS_PER_SEC - 1);
    localparam logic [CNT_W-1:0] WARN_CNT = CNT_W'(TICKS_PER_SEC - WARN_TICKS);

    logic [CNT_W-1:0] cnt;
    logic [EXT_W-1:0] cnt_ext;
    logic [EXT_W-1:0] per_mask;

    // Tick counter: wraps once per second.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt == LAST_CNT) ? '0 : cnt + 1'b1;
    end

    // Strobes decoded from the count.
    always_comb begin
        cnt_ext  = EXT_W'(cnt);
        per_mask = (EXT_W'(2) << rate) - EXT_W'(1);
        step     = tick && (cnt == LAST_CNT);
        warn     = (cnt >= WARN_CNT);
        per_evt  = tick && (rate != 3'd0) && ((cnt_ext & per_mask) == per_mask);
    end

    p_count_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_CNT);
    p_warn_before_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> warn);
    p_warn_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !warn);
    p_hold_without_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
endmodule

// File: rtl/rtc_chain.sv
// Live time counters.
// A load takes priority over a one-second step; the caller keeps the two apart.
module rtc_chain
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t now
);
    // Live register: reset, write-back, or one step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            now <= RTC_RESET_TIME;
        else if (load)
            now <= load_val;
        else if (adv)
            now <= rtc_advance(now);
    end

    p_no_step_on_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv && load));
    p_sec_steps_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && now.sc < 6'd59) |=> now.sc == $past(now.sc) + 6'd1);
    p_idle_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> $stable(now));
    p_day_rolls_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && now.sc == 6'd59 && now.mn == 6'd59 && now.hr == 5'd23 &&
         now.day == rtc_month_len(now.mon, now.yr)) |=> now.day == 5'd1);
endmodule

// File: rtl/rtc_shadow_ctrl.sv
// Top of the double-buffered clock.
// Holds the user copy, the hold and write-back control, the flags and the bus decode.
// Assumes single-cycle bus strobes; reads have no side effect except on the flag address.
module rtc_shadow_ctrl
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int WARN_TICKS    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);
    rtc_time_t  live, usr_q;
    logic       hold_q, pend_q, ufe_q, pfe_q, uf_q, pf_q;
    logic [2:0] rate_q;
    logic       step, warn, per_evt, commit, ctrl_wr, flag_rd;
    logic       unused_wdata;

    assign unused_wdata = ^{bus_wdata[7], bus_wdata[3]};

    rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC), .WARN_TICKS(WARN_TICKS)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rate(rate_q),
        .step(step), .warn(warn), .per_evt(per_evt));

    rtc_chain u_chain (
        .clk(clk), .rst_n(rst_n), .adv(step), .load(commit),
        .load_val(usr_q), .now(live));

    // Decode of strobes and the write-back slot.
    always_comb begin
        ctrl_wr = bus_wr && (bus_addr == ADR_CTRL);
        flag_rd = bus_rd && (bus_addr == ADR_FLAG);
        commit  = pend_q && !warn;
        irq     = (uf_q && ufe_q) || (pf_q && pfe_q);
    end

    // User copy: follows live when released, else frozen or host-written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            usr_q <= RTC_RESET_TIME;
        end else if (!hold_q && !pend_q) begin
            usr_q <= live;
        end else if (hold_q && bus_wr) begin
            case (bus_addr)
                ADR_SEC:  usr_q.sc  <= bus_wdata[5:0];
                ADR_MIN:  usr_q.mn  <= bus_wdata[5:0];
                ADR_HOUR: usr_q.hr  <= bus_wdata[4:0];
                ADR_DAY:  usr_q.day <= bus_wdata[4:0];
                ADR_MON:  usr_q.mon <= bus_wdata[3:0];
                ADR_YEAR: usr_q.yr  <= bus_wdata[6:0];
                default:  ;
            endcase
        end
    end

    // Control register and pending write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            ufe_q  <= 1'b0;
            pfe_q  <= 1'b0;
            rate_q <= 3'd0;
            pend_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                hold_q <= bus_wdata[0];
                ufe_q  <= bus_wdata[1];
                pfe_q  <= bus_wdata[2];
                rate_q <= bus_wdata[6:4];
            end
            if (ctrl_wr && hold_q && !bus_wdata[0])
                pend_q <= 1'b1;
            else if (commit || (ctrl_wr && bus_wdata[0]))
                pend_q <= 1'b0;
        end
    end

    // Event flags: set by events, cleared by reading address 7; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf_q <= 1'b0;
            pf_q <= 1'b0;
        end else begin
            uf_q <= step    || (uf_q && !flag_rd);
            pf_q <= per_evt || (pf_q && !flag_rd);
        end
    end

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            ADR_SEC:  bus_rdata = {2'b00, usr_q.sc};
            ADR_MIN:  bus_rdata = {2'b00, usr_q.mn};
            ADR_HOUR: bus_rdata = {3'b000, usr_q.hr};
            ADR_DAY:  bus_rdata = {3'b000, usr_q.day};
            ADR_MON:  bus_rdata = {4'b0000, usr_q.mon};
            ADR_YEAR: bus_rdata = {1'b0, usr_q.yr};
            ADR_CTRL: bus_rdata = {1'b0, rate_q, 1'b0, pfe_q, ufe_q, hold_q};
            default:  bus_rdata = {irq, 4'b0000, pf_q, uf_q, warn};
        endcase
    end

    p_commit_off_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !step);
    p_copy_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !bus_wr) |=> $stable(usr_q));
    p_deferred_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && warn && !ctrl_wr) |=> pend_q);
    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !step && !per_evt) |=> (!uf_q && !pf_q));
    p_irq_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !flag_rd && !ctrl_wr) |=> irq);
endmodule

// File: tb/rtc_shadow_ctrl_tb.sv
// Bench with a behavioural reference model compared on every cycle.
module rtc_shadow_ctrl_tb;
    localparam int TPS  = 64;
    localparam int WARN = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    rtc_shadow_ctrl #(.TICKS_PER_SEC(TPS), .WARN_TICKS(WARN)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

    always #5 clk = ~clk;

    // Reference model state: index 0 sec, 1 min, 2 hour, 3 day, 4 month, 5 year.
    int m_live[6];
    int m_usr[6];
    int n_live[6];
    int n_usr[6];
    int m_cnt, m_hold, m_pend, m_ufe, m_pfe, m_rate, m_uf, m_pf;
    int t_warn, t_step, t_per, t_cm, t_mask, t_rdf, t_ctrl;
    int fmask[6] = '{63, 63, 31, 31, 15, 127};

    function automatic int mlen(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic int exp_irq();
        return ((m_uf != 0 && m_ufe != 0) || (m_pf != 0 && m_pfe != 0)) ? 1 : 0;
    endfunction

    function automatic int exp_rd(int a);
        if (a < 6) return m_usr[a];
        if (a == 6) return (m_rate << 4) | (m_pfe << 2) | (m_ufe << 1) | m_hold;
        return (exp_irq() << 7) | (m_pf << 2) | (m_uf << 1) | ((m_cnt >= TPS - WARN) ? 1 : 0);
    endfunction

    // Model step on each clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_live = '{0, 0, 0, 1, 1, 0};
            m_usr  = '{0, 0, 0, 1, 1, 0};
            m_cnt = 0; m_hold = 0; m_pend = 0; m_ufe = 0; m_pfe = 0;
            m_rate = 0; m_uf = 0; m_pf = 0;
        end else begin
            t_warn = (m_cnt >= TPS - WARN) ? 1 : 0;
            t_step = (tick && m_cnt == TPS - 1) ? 1 : 0;
            t_mask = (2 << m_rate) - 1;
            t_per  = (tick && m_rate != 0 && ((m_cnt & t_mask) == t_mask)) ? 1 : 0;
            t_cm   = (m_pend != 0 && t_warn == 0) ? 1 : 0;
            t_rdf  = (bus_rd && bus_addr == 3'd7) ? 1 : 0;
            t_ctrl = (bus_wr && bus_addr == 3'd6) ? 1 : 0;
            n_usr = m_usr;
            if (m_hold == 0 && m_pend == 0) n_usr = m_live;
            else if (m_hold != 0 && bus_wr && bus_addr < 3'd6)
                n_usr[bus_addr] = int'(bus_wdata) & fmask[bus_addr];
            n_live = m_live;
            if (t_cm != 0) n_live = m_usr;
            else if (t_step != 0) begin
                n_live[0] = m_live[0] + 1;
                if (n_live[0] == 60) begin n_live[0] = 0; n_live[1] = m_live[1] + 1; end
                if (n_live[1] == 60) begin n_live[1] = 0; n_live[2] = m_live[2] + 1; end
                if (n_live[2] == 24) begin n_live[2] = 0; n_live[3] = m_live[3] + 1; end
                if (n_live[3] > mlen(m_live[4], m_live[5])) begin n_live[3] = 1; n_live[4] = m_live[4] + 1; end
                if (n_live[4] == 13) begin n_live[4] = 1; n_live[5] = m_live[5] + 1; end
                if (n_live[5] == 100) n_live[5] = 0;
            end
            if (t_ctrl != 0 && m_hold != 0 && bus_wdata[0] == 1'b0) m_pend = 1;
            else if (t_cm != 0 || (t_ctrl != 0 && bus_wdata[0])) m_pend = 0;
            if (t_ctrl != 0) begin
                m_hold = bus_wdata[0]; m_ufe = bus_wdata[1]; m_pfe = bus_wdata[2];
                m_rate = int'(bus_wdata[6:4]);
            end
            m_uf = (t_step != 0 || (m_uf != 0 && t_rdf == 0)) ? 1 : 0;
            m_pf = (t_per != 0 || (m_pf != 0 && t_rdf == 0)) ? 1 : 0;
            if (tick) m_cnt = (m_cnt == TPS - 1) ? 0 : m_cnt + 1;
            m_live = n_live;
            m_usr  = n_usr;
        end
    end

    task automatic chk(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Every-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 R4 R7 R8 readback", int'(bus_rdata), exp_rd(int'(bus_addr)));
            chk("R10 irq", int'(irq), exp_irq());
        end
    end

    // Bus tasks: each starts and ends one time unit after a rising edge.
    task automatic wr_reg(int a, int d);
        bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(int a, output int v);
        bus_rd = 1'b1; bus_addr = 3'(a);
        @(negedge clk); v = int'(bus_rdata);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_cnt(int v);
        while (m_cnt != v) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int v, a, b;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // Reset state.
        rd_reg(0, v); chk("R3 reset seconds", v, 0);
        rd_reg(3, v); chk("R3 reset day", v, 1);
        rd_reg(6, v); chk("R4 reset control", v, 0);
        chk("R10 reset irq", int'(irq), 0);
        tick = 1'b1;
        // R1: one step per TPS ticks.
        wait_cnt(5);
        rd_reg(0, a); idle(62); rd_reg(0, b);
        chk("R1 one second step", b, a + 1);
        // R7: warning window edges.
        wait_cnt(TPS - WARN); rd_reg(7, v); chk("R7 warning inside window", v & 1, 1);
        wait_cnt(TPS - WARN - 1); rd_reg(7, v); chk("R7 warning before window", v & 1, 0);
        // R3: writes without hold are ignored.
        idle(3);
        wr_reg(0, 45); idle(1); rd_reg(0, v);
        chk("R3 ignored write", v, m_live[0]);
        // R4: hold, write, stays frozen across steps while flags keep running.
        rd_reg(7, v);
        wr_reg(6, 1);
        wr_reg(0, 50); wr_reg(1, 59); wr_reg(2, 23); wr_reg(3, 28); wr_reg(4, 2); wr_reg(5, 4);
        idle(140);
        rd_reg(0, v); chk("R4 frozen seconds", v, 50);
        rd_reg(7, v); chk("R4 steps continue under hold", (v >> 1) & 1, 1);
        // R5: release outside window, then leap February rollover (R2).
        wait_cnt(10); wr_reg(6, 0); idle(2);
        rd_reg(0, v); chk("R5 write-back seconds", v, 50);
        idle(640);
        rd_reg(3, v); chk("R2 leap day", v, 29);
        rd_reg(2, v); chk("R2 hour wrap", v, 0);
        // R2: non-leap February.
        wr_reg(6, 1);
        wr_reg(0, 59); wr_reg(1, 59); wr_reg(2, 23); wr_reg(3, 28); wr_reg(4, 2); wr_reg(5, 5);
        wait_cnt(10); wr_reg(6, 0); idle(70);
        rd_reg(3, v); chk("R2 non-leap day", v, 1);
        rd_reg(4, v); chk("R2 non-leap month", v, 3);
        // R6: release inside the window, across the end of year 99.
        wr_reg(6, 1);
        wr_reg(0, 59); wr_reg(1, 59); wr_reg(2, 23); wr_reg(3, 31); wr_reg(4, 12); wr_reg(5, 99);
        wait_cnt(TPS - 4); wr_reg(6, 0);
        rd_reg(0, v); chk("R6 still frozen in window", v, 59);
        idle(6);
        rd_reg(0, v); chk("R6 deferred write-back seconds", v, 59);
        rd_reg(5, v); chk("R6 deferred write-back year", v, 99);
        idle(70);
        rd_reg(5, v); chk("R2 year wrap", v, 0);
        rd_reg(4, v); chk("R2 month wrap", v, 1);
        rd_reg(3, v); chk("R2 day wrap", v, 1);
        // R8 R10: update flag with enable.
        wr_reg(6, 2); rd_reg(7, v);
        wait_cnt(0); idle(1);
        chk("R10 irq on update", int'(irq), 1);
        rd_reg(7, v); chk("R8 R10 flag value", v, 8'h82);
        chk("R9 R10 irq after read", int'(irq), 0);
        // R9: read on the step edge keeps the new event.
        wait_cnt(TPS - 1); rd_reg(7, v);
        rd_reg(7, v); chk("R9 set wins over clear", (v >> 1) & 1, 1);
        // R8: periodic flag, period 4 ticks.
        wr_reg(6, 8'h14); rd_reg(7, v);
        idle(4);
        chk("R8 periodic irq", int'(irq), 1);
        rd_reg(7, v); chk("R8 periodic flag", (v >> 2) & 1, 1);
        idle(40);
        // R1: no ticks, no steps.
        tick = 1'b0; rd_reg(0, a); idle(100); rd_reg(0, b);
        chk("R1 prescaler holds", b, a);
        finish_run();
    end
endmodule